// File: doc/BRIEF.md
# Timer clock source selector

This block decides, cycle by cycle, whether a 16-bit timer/counter should advance. A 3-bit select input picks one of eight sources: stopped, every system clock, one of four divided ticks from a shared free-running 10-bit prescaler (ratios 8, 64, 256 and 1024), or falling or rising edges of an external count pin. The result is a one-cycle count-enable strobe, synchronous to the system clock, which the counter uses as its increment qualifier.

The external pin is only ever treated as an input here. Whatever drives it, including the chip's own output driver under software control, produces counts. The pin passes through a two-flop synchronizer and an edge detector before it reaches the selector. A synchronous clear input realigns the prescaler, so software can start a divided count from a known phase.

The selector is an eight-state machine with one state per source: `ST_STOP`, `ST_DIV1`, `ST_DIV8`, `ST_DIV64`, `ST_DIV256`, `ST_DIV1024`, `ST_EXT_FALL` and `ST_EXT_RISE`. On every clock edge it moves to the state named by the select code sampled at that edge. Every transition, including a state to itself, is therefore a single registered step. The output process forwards the enable source that belongs to the current state.

Top module: `tmr_clk_source`

## Requirements
- R1: Select code 000 (`ST_STOP`) keeps `cnt_en` low on every cycle.
- R2: Select code 001 (`ST_DIV1`) holds `cnt_en` high on every cycle.
- R3: Select codes 010, 011, 100 and 101 give divide ratios of 8, 64, 256 and 1024. `cnt_en` is high in exactly those cycles where the low 3, 6, 8 or 10 bits of the prescaler count are all ones. After reset or a clear, the first strobe therefore comes N-1 edges later, and further strobes follow every N cycles.
- R4: Select code 110 produces one strobe for each falling edge of `ext_pin`. If a new pin level is first sampled at clock edge k, the strobe appears in the cycle that follows edge k+1.
- R5: Select code 111 produces one strobe for each rising edge of `ext_pin`, with the same timing as R4.
- R6: While the select code is held at a divided or external source, a strobe is never followed by another strobe in the next cycle.
- R7: A new select code sampled at clock edge k governs `cnt_en` from the cycle after edge k onward. `cnt_en` is one bit, so at most one count is issued per cycle.
- R8: While `rst_n` is low, `cnt_en` is low. Reset also zeroes the prescaler and the synchronizer and selects `ST_STOP`.
- R9: `presc_clr` high at a clock edge sets the prescaler count to zero. No divided strobe can occur in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_clr | input | 1 | Synchronous prescaler clear |
| clk_sel | input | 3 | Clock source select code |
| ext_pin | input | 1 | External count pin, asynchronous |
| cnt_en | output | 1 | One-cycle count-enable strobe |

## Verification
The bench uses the default parameters: a 10-bit prescaler with taps at bits 3, 6, 8 and 10, and a two-stage synchronizer. With a 10-bit prescaler, the divide-by-1024 tick, including its wrap-around, can be observed within a few thousand cycles. Two stages fix the external edge latency at exactly two edges, so the strobe cycle can be predicted exactly. A per-cycle reference model, built from the requirements, follows prescaler clears, abrupt select changes and pin toggles of varying spacing, and queues one expected value for each cycle.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    // Select codes; the numeric values are the software-visible encoding.
    typedef enum logic [2:0] {
        SEL_STOP     = 3'b000,
        SEL_DIV1     = 3'b001,
        SEL_DIV8     = 3'b010,
        SEL_DIV64    = 3'b011,
        SEL_DIV256   = 3'b100,
        SEL_DIV1024  = 3'b101,
        SEL_EXT_FALL = 3'b110,
        SEL_EXT_RISE = 3'b111
    } clk_sel_e;

    // Selector states, one per source.
    typedef enum logic [2:0] {
        ST_STOP,
        ST_DIV1,
        ST_DIV8,
        ST_DIV64,
        ST_DIV256,
        ST_DIV1024,
        ST_EXT_FALL,
        ST_EXT_RISE
    } src_state_e;

    localparam int PRESC_W  = 10;
    localparam int NUM_TAPS = 4;

    // log2 of each divide ratio, in tap order (8, 64, 256, 1024).
    localparam int TAP_LOG2 [NUM_TAPS] = '{3, 6, 8, 10};

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler
    import tcs_pkg::*;
#(
    parameter int W     = PRESC_W,
    parameter int NTAPS = NUM_TAPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [NTAPS-1:0] tick
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // One tick per tap: high when the low log2(N) count bits are all ones.
    for (genvar g = 0; g < NTAPS; g++) begin : g_tap
        localparam int LB = TAP_LOG2[g];
        assign tick[g] = &cnt_q[LB-1:0];
    end

endmodule

// File: rtl/tcs_ext_edge.sv
module tcs_ext_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= synced;
        end
    end

    assign rise = synced & ~prev_q;
    assign fall = ~synced & prev_q;

endmodule

// File: rtl/tcs_sel_fsm.sv
module tcs_sel_fsm
    import tcs_pkg::*;
#(
    parameter int NTAPS = NUM_TAPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       sel,
    input  logic [NTAPS-1:0] tick,
    input  logic             ext_rise,
    input  logic             ext_fall,
    output logic             cnt_en
);

    src_state_e state_q;
    src_state_e state_d;

    // Next-state decode: the select code names the next state directly.
    always_comb begin
        unique case (clk_sel_e'(sel))
            SEL_STOP:     state_d = ST_STOP;
            SEL_DIV1:     state_d = ST_DIV1;
            SEL_DIV8:     state_d = ST_DIV8;
            SEL_DIV64:    state_d = ST_DIV64;
            SEL_DIV256:   state_d = ST_DIV256;
            SEL_DIV1024:  state_d = ST_DIV1024;
            SEL_EXT_FALL: state_d = ST_EXT_FALL;
            SEL_EXT_RISE: state_d = ST_EXT_RISE;
            default:      state_d = ST_STOP;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process: forward the enable source of the current state.
    always_comb begin
        unique case (state_q)
            ST_STOP:     cnt_en = 1'b0;
            ST_DIV1:     cnt_en = 1'b1;
            ST_DIV8:     cnt_en = tick[0];
            ST_DIV64:    cnt_en = tick[1];
            ST_DIV256:   cnt_en = tick[2];
            ST_DIV1024:  cnt_en = tick[3];
            ST_EXT_FALL: cnt_en = ext_fall;
            ST_EXT_RISE: cnt_en = ext_rise;
            default:     cnt_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_clk_source.sv
module tmr_clk_source
    import tcs_pkg::*;
#(
    parameter int PRESC_WIDTH = PRESC_W,
    parameter int SYNC_DEPTH  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       presc_clr,
    input  logic [2:0] clk_sel,
    input  logic       ext_pin,
    output logic       cnt_en
);

    localparam int NT = NUM_TAPS;

    logic [NT-1:0] tick;
    logic          ext_rise;
    logic          ext_fall;

    tcs_prescaler #(
        .W     (PRESC_WIDTH),
        .NTAPS (NT)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (presc_clr),
        .tick  (tick)
    );

    tcs_ext_edge #(
        .SYNC_STAGES (SYNC_DEPTH)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin),
        .rise  (ext_rise),
        .fall  (ext_fall)
    );

    tcs_sel_fsm #(
        .NTAPS (NT)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (clk_sel),
        .tick     (tick),
        .ext_rise (ext_rise),
        .ext_fall (ext_fall),
        .cnt_en   (cnt_en)
    );

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       presc_clr,
    input logic [2:0] clk_sel,
    input logic       cnt_en
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    assert_stop_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(clk_sel) == 3'b000) |-> !cnt_en);

    assert_div1_every_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(clk_sel) == 3'b001) |-> cnt_en);

    assert_no_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && cnt_en && $past(clk_sel) >= 3'b010
         && clk_sel == $past(clk_sel)) |=> !cnt_en);

    assert_clear_blocks_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_clr && clk_sel >= 3'b010 && clk_sel <= 3'b101) |=> !cnt_en);

endmodule

bind tmr_clk_source tcs_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .presc_clr (presc_clr),
    .clk_sel   (clk_sel),
    .cnt_en    (cnt_en)
);

// File: tb/tmr_clk_source_bench.sv
module tmr_clk_source_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       presc_clr = 1'b0;
    logic [2:0] clk_sel = 3'b000;
    logic       ext_pin = 1'b0;
    logic       cnt_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    bit    exp_q [$];
    string tag_q [$];

    // Reference state, derived from the requirements.
    logic [9:0] m_cnt = '0;
    logic       m_s1 = 1'b0, m_s2 = 1'b0, m_prev = 1'b0;
    logic [2:0] m_sel = 3'b000;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_clk_source u_tmr_clk_source (
        .clk       (clk),
        .rst_n     (rst_n),
        .presc_clr (presc_clr),
        .clk_sel   (clk_sel),
        .ext_pin   (ext_pin),
        .cnt_en    (cnt_en)
    );

    function automatic bit model_out();
        unique case (m_sel)
            3'd0: return 1'b0;
            3'd1: return 1'b1;
            3'd2: return &m_cnt[2:0];
            3'd3: return &m_cnt[5:0];
            3'd4: return &m_cnt[7:0];
            3'd5: return &m_cnt[9:0];
            3'd6: return ~m_s2 & m_prev;
            default: return m_s2 & ~m_prev;
        endcase
    endfunction

    // Driver: called just after a falling edge; returns just after the next one.
    task automatic step(input logic [2:0] sel, input logic pin,
                        input logic clr, input string tag);
        clk_sel   = sel;
        ext_pin   = pin;
        presc_clr = clr;
        @(posedge clk);
        m_cnt  = clr ? 10'd0 : m_cnt + 10'd1;
        m_prev = m_s2;
        m_s2   = m_s1;
        m_s1   = pin;
        m_sel  = sel;
        #1;
        exp_q.push_back(model_out());
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic run(input logic [2:0] sel, input int n, input string tag);
        for (int i = 0; i < n; i++) step(sel, ext_pin, 1'b0, tag);
    endtask

    // Monitor: pops one expectation per cycle and compares.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (cnt_en !== e) begin
                n_fail++;
                $display("FAIL %s: cnt_en=%b expected=%b at %0t", t, cnt_en, e, $time);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        // R8: output quiet during reset, even with div1 selected.
        clk_sel = 3'b001;
        repeat (4) begin
            @(negedge clk);
            n_checks++;
            if (cnt_en !== 1'b0) begin
                n_fail++;
                $display("FAIL R8: cnt_en=%b expected=0 in reset", cnt_en);
            end
        end
        clk_sel = 3'b000;
        rst_n = 1'b1;

        run(3'b000, 30, "R1");
        run(3'b001, 20, "R2");
        run(3'b010, 40, "R3 div8 R8");
        run(3'b011, 200, "R3 div64");
        run(3'b100, 600, "R3 div256");
        run(3'b101, 2200, "R3 div1024");

        // R9: clear realigns the divided ticks.
        step(3'b010, 1'b0, 1'b1, "R9");
        run(3'b010, 20, "R9");
        step(3'b011, 1'b0, 1'b1, "R9");
        run(3'b011, 70, "R9");

        // R4: falling edges, with varied spacing.
        step(3'b110, 1'b1, 1'b0, "R4 R6");
        for (int k = 1; k <= 6; k++) begin
            for (int j = 0; j < k; j++) step(3'b110, 1'b1, 1'b0, "R4 R6");
            for (int j = 0; j < k + 1; j++) step(3'b110, 1'b0, 1'b0, "R4 R6");
        end
        run(3'b110, 4, "R4");

        // R5: rising edges, including single-cycle pulses on the pin.
        for (int k = 1; k <= 6; k++) begin
            for (int j = 0; j < k; j++) step(3'b111, 1'b1, 1'b0, "R5 R6");
            for (int j = 0; j < 3; j++) step(3'b111, 1'b0, 1'b0, "R5 R6");
        end
        run(3'b111, 4, "R5");

        // R7: abrupt select changes while the pin toggles.
        for (int k = 0; k < 64; k++) begin
            step(3'((k * 5 + k / 3) % 8), logic'(k[1]), logic'(k % 11 == 0), "R7");
        end
        run(3'b000, 10, "R1 R7");

        finish_run();
    end

endmodule